// File: doc/BRIEF.md
# Lane-Partitioned Packed Adder

This block adds or subtracts two 64-bit operands as a set of independent lanes. A two-bit lane-size select splits the operands into eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. Every lane has its own arithmetic. A carry or borrow never passes from one lane into the lane above it, so one instruction-style operation does the work of several narrow adds.

The lane boundaries are set at run time by breaking a single byte-granular carry chain at the bottom of each lane. Subtraction inverts the second operand and injects a carry-in of one at the foot of every lane. The carry out of each lane is reported in a per-byte vector. The result, the carry vector and a valid flag are registered, so they appear one cycle after a valid input. A single 64-bit add is deliberately not offered as a mode.

Top module: `packed_lane_adder`

## Requirements
- R1: `lane_sel` picks the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 gives four 16-bit lanes and 2'b10 gives two 32-bit lanes. Lane k occupies bits [k*w +: w].
- R2: No carry or borrow crosses a lane boundary. The result of each lane depends only on that lane's bits of `a` and `b`.
- R3: Each lane wraps on overflow and keeps only the low w bits of its sum.
- R4: With `sub` high, each lane computes a minus b modulo 2^w as a + ~b + 1. The lane's carry-out is then 1 exactly when a >= b, taken unsigned.
- R5: The carry out of each lane appears in `carry_out` at the bit of that lane's most significant byte (byte index k*w/8 + w/8 - 1). Every other bit is 0.
- R6: `lane_sel` = 2'b11 is reserved. A valid input with this code registers a zero result and a zero carry vector.
- R7: `sum` and `carry_out` load on a clock edge where `in_valid` is high. When `in_valid` is low they hold their previous values.
- R8: `out_valid` equals `in_valid` delayed by one clock.
- R9: While `rst_n` is low, `out_valid`, `sum` and `carry_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands valid; load the result |
| lane_sel | input | 2 | Lane width select |
| sub | input | 1 | 1 = subtract b from a, 0 = add |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| out_valid | output | 1 | Registered valid |
| sum | output | 64 | Registered lane results |
| carry_out | output | 8 | Registered per-byte lane carry vector |

## Verification
Operands of all ones plus one are applied in every lane width. This separates correct wrapping and lane isolation from a chain that leaks carries, because a leak turns the zero lanes into ones. Subtracting one from zero, and subtracting equal values, separates the borrow polarity and the per-lane carry-in injection. Random operands in both directions and all three widths catch carry-vector bits placed at the wrong byte. Idle cycles fed with changed operands, and the reserved code, show that the outputs hold or clear as required.

// File: rtl/packed_lane_adder.sv
module packed_lane_adder #(
  parameter int BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [1:0]           lane_sel,
  input  logic                 sub,
  input  logic [8*BYTES-1:0]   a,
  input  logic [8*BYTES-1:0]   b,
  output logic                 out_valid,
  output logic [8*BYTES-1:0]   sum,
  output logic [BYTES-1:0]     carry_out
);
  localparam int W = 8 * BYTES;

  logic [BYTES:0]   chain;
  logic [W-1:0]     sum_d;
  logic [BYTES-1:0] co_d;
  logic             mode_ok;

  assign mode_ok  = (lane_sel != 2'b11);
  assign chain[0] = sub;

  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    logic       start, top, cin;
    logic [7:0] bx;
    logic [8:0] t;
    assign start = (lane_sel == 2'b00) || (lane_sel == 2'b01 && (i % 2) == 0)
                || (lane_sel == 2'b10 && (i % 4) == 0);
    assign top   = (lane_sel == 2'b00) || (lane_sel == 2'b01 && (i % 2) == 1)
                || (lane_sel == 2'b10 && (i % 4) == 3);
    assign bx    = b[8*i +: 8] ^ {8{sub}};
    assign cin   = start ? sub : chain[i];
    assign t     = {1'b0, a[8*i +: 8]} + {1'b0, bx} + {8'd0, cin};
    assign chain[i+1]  = t[8];
    assign sum_d[8*i +: 8] = t[7:0];
    assign co_d[i] = t[8] & top;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      carry_out <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum       <= mode_ok ? sum_d : '0;
        carry_out <= mode_ok ? co_d  : '0;
      end
    end
  end
endmodule

// File: rtl/packed_lane_adder_chk.sv
module packed_lane_adder_chk #(
  parameter int BYTES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         lane_sel,
  input logic               out_valid,
  input logic [8*BYTES-1:0] sum,
  input logic [BYTES-1:0]   carry_out
);
  function automatic logic [BYTES-1:0] non_top(input int per);
    logic [BYTES-1:0] m;
    for (int i = 0; i < BYTES; i++) m[i] = ((i % per) != per - 1);
    return m;
  endfunction

  localparam logic [BYTES-1:0] NT16 = non_top(2);
  localparam logic [BYTES-1:0] NT32 = non_top(4);

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R7
  hold_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(sum) && $stable(carry_out)));
  // R5
  carry16_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b01) |=> ((carry_out & NT16) == '0));
  // R5
  carry32_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b10) |=> ((carry_out & NT32) == '0));
  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && lane_sel == 2'b11) |=> (sum == '0 && carry_out == '0));
endmodule

bind packed_lane_adder packed_lane_adder_chk #(.BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane_sel(lane_sel),
  .out_valid(out_valid), .sum(sum), .carry_out(carry_out)
);

// File: tb/tb_packed_lane_adder.sv
module tb_packed_lane_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  lane_sel = 2'b00;
  logic        sub = 1'b0;
  logic [63:0] a = '0, b = '0;
  logic        out_valid;
  logic [63:0] sum;
  logic [7:0]  carry_out;

  logic [63:0] exp_sum = '0;
  logic [7:0]  exp_co = '0;
  logic        exp_v = 1'b0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  packed_lane_adder dut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .lane_sel(lane_sel), .sub(sub), .a(a), .b(b), .out_valid(out_valid),
    .sum(sum), .carry_out(carry_out));

  task automatic model(input logic [1:0] sel, input logic s,
                       input logic [63:0] x, input logic [63:0] y);
    int w;
    longint unsigned mask, xa, yb, r;
    exp_sum = '0;
    exp_co  = '0;
    if (sel == 2'b11) return;
    w = 8 << sel;
    mask = (64'd1 << w) - 1;
    for (int k = 0; k < 64 / w; k++) begin
      xa = (x >> (k * w)) & mask;
      yb = (y >> (k * w)) & mask;
      r  = s ? (xa + ((~yb) & mask) + 1) : (xa + yb);
      exp_sum |= (r & mask) << (k * w);
      exp_co[k * (w / 8) + w / 8 - 1] = ((r >> w) & 1) != 0;
    end
  endtask

  task automatic check(input string tag);
    total++;
    if (out_valid !== exp_v || sum !== exp_sum || carry_out !== exp_co) begin
      bad++;
      $display("FAIL %s: got v=%b sum=%h co=%b, want v=%b sum=%h co=%b",
               tag, out_valid, sum, carry_out, exp_v, exp_sum, exp_co);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [1:0] sel,
                      input logic s, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    in_valid = v; lane_sel = sel; sub = s; a = x; b = y;
    @(posedge clk);
    exp_v = v;
    if (v) model(sel, s, x, y);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset");
    rst_n = 1'b1;
    for (int m = 0; m < 3; m++) begin
      step("R1 R2 R3 ones plus one", 1, m[1:0], 0, '1,
           (m == 0) ? 64'h0101010101010101 : (m == 1) ? 64'h0001000100010001
                                                      : 64'h0000000100000001);
      step("R4 zero minus one", 1, m[1:0], 1, '0,
           (m == 0) ? 64'h0101010101010101 : (m == 1) ? 64'h0001000100010001
                                                      : 64'h0000000100000001);
      step("R4 R5 equal subtract", 1, m[1:0], 1, 64'h0123456789abcdef, 64'h0123456789abcdef);
      step("R2 alternate lanes", 1, m[1:0], 0, 64'hff00ff00ffff0000, 64'h0100010000010000);
    end
    step("R7 idle hold", 0, 2'b00, 1, 64'h5555, 64'h7777);
    step("R8 idle again", 0, 2'b10, 0, '1, '1);
    step("R6 reserved", 1, 2'b11, 0, '1, '1);
    step("R7 hold after reserved", 0, 2'b00, 0, '1, 64'h1);
    for (int n = 0; n < 60; n++) begin
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 2));
      step("R1 R3 R4 R5 random", 1'($urandom_range(0, 3) != 0), sel,
           1'($urandom_range(0, 1)), {$urandom, $urandom}, {$urandom, $urandom});
    end
    rst_n = 1'b0;
    @(posedge clk);
    exp_v = 0; exp_sum = '0; exp_co = '0;
    @(negedge clk);
    check("R9 reset again");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule